// File: doc/BRIEF.md
# UART Modem Loopback Controller

This block is the internal loopback path of a UART. A loopback-enable bit in the control register selects between two modes. In normal mode the modem-status flags track the external modem input pins. Received bytes from the external receive path flow into the receive FIFO. Transmitted words leave only towards the line.

With loopback on, the four modem-control outputs held in the control register are cross-mapped onto the modem-status flags. The four modem-status raw interrupt bits are rebuilt from the resulting flag levels. Every transmit word is copied into the receive FIFO. A rising send-break request injects a break marker word into the receive FIFO. Bytes from the external receive path are accepted and dropped.

The receive-FIFO push port, the transmit path and the external receive path are valid/ready streams. The push port holds one word in an output register. While `push_valid` is high and `push_ready` is low, the word and its valid stay unchanged. A source is accepted only when that register is empty or draining in the same cycle. In loopback mode a transmit word and a break request can compete for the push port. The transmit word wins, and the break waits in a single pending slot.

Top module: `uart_lpbk_ctrl`

## Requirements
- R1: After reset, `mdm_flags` and `ms_irq` are 0, `push_valid` is 0, and both `tx_ready` and `rx_ready` are 1.
- R2: Control word bit positions are: 0 loopback enable, 1 DTR, 2 RTS, 3 OUT1, 4 OUT2. Flag and interrupt vector bit positions are: 0 RI, 1 DCD, 2 CTS, 3 DSR. In the cycle after a control write with bit 0 set, the mapping is RI=OUT2, DCD=OUT1, CTS=RTS and DSR=DTR. The external pins have no effect while loopback stays on.
- R3: The mapping applies on the very control write that turns loopback on, using the modem outputs carried in that same write.
- R4: On each control write with loopback set, `ms_irq` becomes equal to the new flag vector. Bits whose flag is 0 are cleared. Bits whose flag is 1 are set again, even when the flag did not change.
- R5: A 1 in `ms_irq_clr` clears the matching `ms_irq` bit in the next cycle. When a loopback control write arrives in the same cycle, the write's result wins.
- R6: While loopback is off and no write turns it on, `mdm_flags` equals `mdm_pins` one cycle later. A control write with bit 0 clear leaves `ms_irq` unchanged.
- R7: With loopback on, each accepted transmit word appears on the push port one cycle later, zero-extended to the push word width. With loopback off, transmit words are always accepted and never pushed.
- R8: With loopback on, a line-control write that raises the send-break bit from 0 to 1 pushes a word with only bit 10 set. A write that keeps the bit at 1 pushes nothing, and so does a write that clears it.
- R9: With loopback on, `rx_ready` is 1 and external receive bytes are dropped without a push.
- R10: With loopback off, an accepted receive byte appears on the push port one cycle later, zero-extended. While `push_valid` is 1 and `push_ready` is 0, `push_data` stays stable and `rx_ready` is 0.
- R11: When a transmit word and a break request arrive in the same loopback cycle, the transmit word is pushed first and the break word follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 5 | Control register write value |
| lcr_wr_en | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Send-break bit of the line-control write |
| mdm_pins | input | 4 | External modem status pins (RI, DCD, CTS, DSR) |
| ms_irq_clr | input | 4 | Clear mask for modem-status interrupt bits |
| tx_valid | input | 1 | Transmit word valid |
| tx_data | input | 8 | Transmit word |
| tx_ready | output | 1 | Transmit word accepted |
| rx_valid | input | 1 | External receive byte valid |
| rx_data | input | 8 | External receive byte |
| rx_ready | output | 1 | External receive byte accepted |
| push_valid | output | 1 | Receive FIFO push valid |
| push_data | output | 11 | Receive FIFO push word, bit 10 marks break |
| push_ready | input | 1 | Receive FIFO can take the word |
| mdm_flags | output | 4 | Modem-status flags |
| ms_irq | output | 4 | Modem-status raw interrupt bits |

## Verification
The hardest case to reach is a transmit word and a break request landing on the push port in the same cycle. The break request is only seen as a rising edge on a line-control write. The stimulus first drops the send-break bit with loopback still on. It then raises the bit in the same cycle as a transmit strobe and reads two successive push words. A second awkward case is a level-based interrupt rebuild after a software clear. The bench clears a bit and then repeats an identical control write. It expects the bit to return even though no flag changed.

// File: rtl/uart_lpbk_pkg.sv
package uart_lpbk_pkg;
  localparam int CTL_W    = 5;
  localparam int CTL_LPBK = 0;
  localparam int CTL_DTR  = 1;
  localparam int CTL_RTS  = 2;
  localparam int CTL_OUT1 = 3;
  localparam int CTL_OUT2 = 4;

  localparam int MDM_W   = 4;
  localparam int MDM_RI  = 0;
  localparam int MDM_DCD = 1;
  localparam int MDM_CTS = 2;
  localparam int MDM_DSR = 3;

  // Cross-map control outputs onto modem status positions.
  function automatic logic [MDM_W-1:0] ctl_to_mdm(input logic [CTL_W-1:0] c);
    logic [MDM_W-1:0] m;
    m          = '0;
    m[MDM_RI]  = c[CTL_OUT2];
    m[MDM_DCD] = c[CTL_OUT1];
    m[MDM_CTS] = c[CTL_RTS];
    m[MDM_DSR] = c[CTL_DTR];
    return m;
  endfunction
endpackage

// File: rtl/uart_lpbk_modem.sv
module uart_lpbk_modem
  import uart_lpbk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             lpbk_on,
  input  logic [MDM_W-1:0] mdm_pins,
  input  logic [MDM_W-1:0] ms_irq_clr,
  output logic [MDM_W-1:0] mdm_flags,
  output logic [MDM_W-1:0] ms_irq
);
  logic             lb_write;
  logic [MDM_W-1:0] mapped;

  assign lb_write = ctl_wr_en && ctl_wr_data[CTL_LPBK];
  assign mapped   = ctl_to_mdm(ctl_wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdm_flags <= '0;
    end else if (lb_write) begin
      mdm_flags <= mapped;
    end else if (!lpbk_on) begin
      mdm_flags <= mdm_pins;
    end
  end

  for (genvar i = 0; i < MDM_W; i++) begin : g_irq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ms_irq[i] <= 1'b0;
      end else if (lb_write) begin
        ms_irq[i] <= mapped[i];
      end else if (ms_irq_clr[i]) begin
        ms_irq[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_lpbk_push.sv
module uart_lpbk_push #(
  parameter int DATA_W = 8,
  parameter int WORD_W = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lpbk_on,
  input  logic              brk_trig,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              push_valid,
  output logic [WORD_W-1:0] push_data,
  input  logic              push_ready
);
  localparam int BRK_BIT = WORD_W - 1;
  localparam logic [WORD_W-1:0] BRK_WORD = WORD_W'(1) << BRK_BIT;

  logic slot_free, brk_want, brk_go, brk_pend;
  logic tx_go, rx_go, load;
  logic [WORD_W-1:0] load_word;

  assign slot_free = !push_valid || push_ready;
  assign brk_want  = lpbk_on && (brk_trig || brk_pend);
  assign tx_go     = lpbk_on && tx_valid && slot_free;
  assign brk_go    = brk_want && slot_free && !tx_valid;
  assign rx_go     = !lpbk_on && rx_valid && slot_free;
  assign tx_ready  = lpbk_on ? slot_free : 1'b1;
  assign rx_ready  = lpbk_on ? 1'b1 : slot_free;
  assign load      = tx_go || brk_go || rx_go;

  always_comb begin
    if (tx_go)       load_word = WORD_W'(tx_data);
    else if (brk_go) load_word = BRK_WORD;
    else             load_word = WORD_W'(rx_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_pend   <= 1'b0;
      push_valid <= 1'b0;
      push_data  <= '0;
    end else begin
      brk_pend <= brk_want && !brk_go;
      if (load) begin
        push_valid <= 1'b1;
        push_data  <= load_word;
      end else if (push_ready) begin
        push_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_lpbk_ctrl.sv
module uart_lpbk_ctrl
  import uart_lpbk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [CTL_W-1:0]  ctl_wr_data,
  input  logic              lcr_wr_en,
  input  logic              lcr_brk,
  input  logic [MDM_W-1:0]  mdm_pins,
  input  logic [MDM_W-1:0]  ms_irq_clr,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              push_valid,
  output logic [WORD_W-1:0] push_data,
  input  logic              push_ready,
  output logic [MDM_W-1:0]  mdm_flags,
  output logic [MDM_W-1:0]  ms_irq
);
  logic [CTL_W-1:0] ctl_q;
  logic             brk_q;
  logic             lpbk_on;
  logic             brk_trig;

  assign lpbk_on  = ctl_q[CTL_LPBK];
  assign brk_trig = lcr_wr_en && lcr_brk && !brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      brk_q <= 1'b0;
    end else begin
      if (ctl_wr_en) ctl_q <= ctl_wr_data;
      if (lcr_wr_en) brk_q <= lcr_brk;
    end
  end

  uart_lpbk_modem u_modem (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr_en  (ctl_wr_en),
    .ctl_wr_data(ctl_wr_data),
    .lpbk_on    (lpbk_on),
    .mdm_pins   (mdm_pins),
    .ms_irq_clr (ms_irq_clr),
    .mdm_flags  (mdm_flags),
    .ms_irq     (ms_irq)
  );

  uart_lpbk_push #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_push (
    .clk       (clk),
    .rst_n     (rst_n),
    .lpbk_on   (lpbk_on),
    .brk_trig  (brk_trig),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .push_valid(push_valid),
    .push_data (push_data),
    .push_ready(push_ready)
  );
endmodule

// File: rtl/uart_lpbk_ctrl_chk.sv
module uart_lpbk_ctrl_chk
  import uart_lpbk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = DATA_W + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr_en,
  input logic [CTL_W-1:0]  ctl_wr_data,
  input logic              lpbk_on,
  input logic [MDM_W-1:0]  mdm_pins,
  input logic [MDM_W-1:0]  mdm_flags,
  input logic [MDM_W-1:0]  ms_irq,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              push_valid,
  input logic [WORD_W-1:0] push_data,
  input logic              push_ready
);
  AST_LB_FLAGS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && ctl_wr_data[CTL_LPBK] |=>
      mdm_flags[MDM_RI] == $past(ctl_wr_data[CTL_OUT2]) &&
      mdm_flags[MDM_DSR] == $past(ctl_wr_data[CTL_DTR])); // R2

  AST_IRQ_FROM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && ctl_wr_data[CTL_LPBK] |=> ms_irq == mdm_flags); // R4

  AST_OFF_FOLLOW_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !lpbk_on && !(ctl_wr_en && ctl_wr_data[CTL_LPBK]) |=> mdm_flags == $past(mdm_pins)); // R6

  AST_RX_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    lpbk_on && rx_valid |-> rx_ready); // R9

  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_data)); // R10

  AST_BRK_WORD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_data[WORD_W-1] |-> push_data[WORD_W-2:0] == '0); // R8
endmodule

bind uart_lpbk_ctrl uart_lpbk_ctrl_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr_en  (ctl_wr_en),
  .ctl_wr_data(ctl_wr_data),
  .lpbk_on    (lpbk_on),
  .mdm_pins   (mdm_pins),
  .mdm_flags  (mdm_flags),
  .ms_irq     (ms_irq),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .push_valid (push_valid),
  .push_data  (push_data),
  .push_ready (push_ready)
);

// File: tb/uart_lpbk_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_lpbk_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [4:0]  ctl_wr_data = '0;
  logic        lcr_wr_en = 1'b0;
  logic        lcr_brk = 1'b0;
  logic [3:0]  mdm_pins = '0;
  logic [3:0]  ms_irq_clr = '0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        push_valid;
  logic [10:0] push_data;
  logic        push_ready = 1'b1;
  logic [3:0]  mdm_flags;
  logic [3:0]  ms_irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  uart_lpbk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .lcr_wr_en(lcr_wr_en), .lcr_brk(lcr_brk),
    .mdm_pins(mdm_pins), .ms_irq_clr(ms_irq_clr),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .mdm_flags(mdm_flags), .ms_irq(ms_irq)
  );

  // control bits: 0 lpbk,1 dtr,2 rts,3 out1,4 out2; flags: 0 ri,1 dcd,2 cts,3 dsr
  localparam logic [4:0] LB = 5'b00001, DTR = 5'b00010, RTS = 5'b00100,
                         OUT1 = 5'b01000, OUT2 = 5'b10000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [4:0] v);
    @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(negedge clk); ctl_wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 flags", mdm_flags, 0);
    chk("R1 irq", ms_irq, 0);
    chk("R1 push_valid", push_valid, 0);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_ready", rx_ready, 1);
  endtask

  task automatic t_off_pins;
    @(negedge clk); mdm_pins = 4'b1010;
    @(negedge clk);
    chk("R6 flags follow pins", mdm_flags, 4'b1010);
    ctl_write(DTR | RTS | OUT1 | OUT2);
    chk("R6 irq untouched by off write", ms_irq, 0);
    chk("R6 flags still pins", mdm_flags, 4'b1010);
  endtask

  task automatic t_enable;
    ctl_write(LB | DTR);
    chk("R3 map on enabling write", mdm_flags, 4'b1000);
    chk("R4 irq rebuilt", ms_irq, 4'b1000);
    @(negedge clk);
    chk("R2 pins ignored in loopback", mdm_flags, 4'b1000);
  endtask

  task automatic t_map;
    ctl_write(LB | OUT2);
    chk("R2 out2 to ri", mdm_flags, 4'b0001);
    chk("R4 dsr irq cleared", ms_irq, 4'b0001);
    ctl_write(LB | OUT1 | RTS);
    chk("R2 out1/rts to dcd/cts", mdm_flags, 4'b0110);
    chk("R4 irq levels", ms_irq, 4'b0110);
  endtask

  task automatic t_clear;
    @(negedge clk); ms_irq_clr = 4'b0010;
    @(negedge clk); ms_irq_clr = 4'b0000;
    chk("R5 clear bit", ms_irq, 4'b0100);
    ctl_write(LB | OUT1 | RTS);
    chk("R4 same write resets bit", ms_irq, 4'b0110);
    @(negedge clk); ms_irq_clr = 4'b1111; ctl_wr_en = 1'b1; ctl_wr_data = LB | OUT1 | RTS;
    @(negedge clk); ms_irq_clr = 4'b0000; ctl_wr_en = 1'b0;
    chk("R5 write wins over clear", ms_irq, 4'b0110);
  endtask

  task automatic t_tx_lb;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'hA5;
    chk("R7 tx_ready", tx_ready, 1);
    @(negedge clk); tx_valid = 1'b0;
    chk("R7 tx pushed valid", push_valid, 1);
    chk("R7 tx pushed data", push_data, 11'h0A5);
    rx_valid = 1'b1; rx_data = 8'h3C;
    #1 chk("R9 rx_ready in loopback", rx_ready, 1);
    @(negedge clk); rx_valid = 1'b0;
    chk("R9 rx dropped", push_valid, 0);
  endtask

  task automatic t_break;
    @(negedge clk); lcr_wr_en = 1'b1; lcr_brk = 1'b1;
    @(negedge clk); lcr_wr_en = 1'b0;
    chk("R8 break valid", push_valid, 1);
    chk("R8 break word", push_data, 11'h400);
    @(negedge clk); lcr_wr_en = 1'b1; lcr_brk = 1'b1;
    @(negedge clk); lcr_wr_en = 1'b0;
    chk("R8 no push on held break", push_valid, 0);
    @(negedge clk); lcr_wr_en = 1'b1; lcr_brk = 1'b0;
    @(negedge clk); lcr_wr_en = 1'b0;
    chk("R8 no push on falling break", push_valid, 0);
  endtask

  task automatic t_prio;
    @(negedge clk); lcr_wr_en = 1'b1; lcr_brk = 1'b1; tx_valid = 1'b1; tx_data = 8'h11;
    @(negedge clk); lcr_wr_en = 1'b0; tx_valid = 1'b0;
    chk("R11 tx first", {push_valid, push_data}, {1'b1, 11'h011});
    @(negedge clk);
    chk("R11 break second", {push_valid, push_data}, {1'b1, 11'h400});
    @(negedge clk);
    chk("R11 nothing more", push_valid, 0);
    @(negedge clk); lcr_wr_en = 1'b1; lcr_brk = 1'b0;
    @(negedge clk); lcr_wr_en = 1'b0;
  endtask

  task automatic t_off_paths;
    ctl_write(5'b00000);
    @(negedge clk);
    chk("R6 flags back to pins", mdm_flags, 4'b1010);
    chk("R6 irq kept", ms_irq, 4'b0110);
    tx_valid = 1'b1; tx_data = 8'h77;
    @(negedge clk); tx_valid = 1'b0;
    chk("R7 no tx push when off", push_valid, 0);
    rx_valid = 1'b1; rx_data = 8'h3C;
    @(negedge clk); rx_valid = 1'b0;
    chk("R10 rx pushed", {push_valid, push_data}, {1'b1, 11'h03C});
    @(negedge clk); lcr_wr_en = 1'b1; lcr_brk = 1'b1;
    @(negedge clk); lcr_wr_en = 1'b0;
    chk("R8 no break push when off", push_valid, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk); push_ready = 1'b0; rx_valid = 1'b1; rx_data = 8'h55;
    @(negedge clk); rx_data = 8'h66;
    chk("R10 first word", {push_valid, push_data}, {1'b1, 11'h055});
    chk("R10 rx_ready low when full", rx_ready, 0);
    @(negedge clk);
    chk("R10 word held", {push_valid, push_data}, {1'b1, 11'h055});
    push_ready = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    chk("R10 next word after drain", {push_valid, push_data}, {1'b1, 11'h066});
    @(negedge clk);
    chk("R10 drained", push_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_off_pins;
    t_enable;
    t_map;
    t_clear;
    t_tx_lb;
    t_break;
    t_prio;
    t_off_paths;
    t_backpressure;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule